// File: doc/BRIEF.md
# IrDA SIR Receive Pulse Stretcher

This block turns the short, active-low light pulses reported by an infrared receiver into a plain NRZ serial stream that a UART receiver can sample. Each accepted pulse marks a zero bit. The block answers it by pulling the NRZ output low for one full bit period. That period is rebuilt from a tick that runs at sixteen times the bit rate, so the width of the incoming pulse has no effect on the output.

The infrared input is asynchronous. It passes through a reset-to-idle synchronizer chain, and a falling edge detector follows the chain. An echo gate can block the receive path while the local transmitter is sending, and it keeps the path blocked for a programmable number of ticks afterwards so the receiver can recover from its own light. A control input enables the gate. An active-low activity indicator is also driven.

Two small state machines control the block. The stretcher has `ST_IDLE` and `ST_STRETCH`. It goes from idle to stretch on an accepted falling edge. It stays in stretch and clears its tick count when another edge is accepted. It returns to idle on the sixteenth tick. The echo gate has `G_OPEN`, `G_TX` and `G_HOLD`:
- It goes from open to tx when suppression is on and the transmitter is busy.
- From tx it goes to hold when the transmitter goes quiet, loading the latency count. If the latency count is zero it goes straight back to open.
- From hold it goes back to tx if the transmitter becomes busy again. It goes to open after the last latency tick.
- Every state goes back to open as soon as suppression is switched off.

Top module: `irsir_rx_stretch`

## Requirements
- R1: During and right after reset, `nrz_rx_o` and `rx_led_n_o` are high (idle), and both stay high until an accepted falling edge arrives.
- R2: The input is first seen low at rising edge s. If the gate is open, `nrz_rx_o` goes low after rising edge s+2, and it is still high after edge s+1.
- R3: After one accepted edge, `nrz_rx_o` stays low for a single contiguous run that ends on the 16th tick after entry. With a tick every D cycles, that run lasts 15·D+1 to 16·D cycles.
- R4: A falling edge accepted while the output is already low restarts the count. The low run then ends 15·D+1 to 16·D cycles after that second edge is accepted (entry at its s+2).
- R5: The output timing does not change with the input pulse width, from one clock cycle to longer than a whole bit. An input held low after the stretch ends does not keep the output low.
- R6: With `echo_sup_i` = 1, a falling edge that arrives while `tx_busy_i` is high produces no low output and no indicator activity.
- R7: With `echo_sup_i` = 1, edges stay blocked for `lat_ticks_i` ticks after `tx_busy_i` falls, and edges after that window are accepted. A latency of 0 reopens the gate on the first cycle the transmitter is seen idle.
- R8: With `echo_sup_i` = 0, edges that arrive during transmission are decoded normally.
- R9: `rx_led_n_o` is low whenever `nrz_rx_o` is low. It is also low while an ungated input remains low after the stretch has ended, and it is high when idle.
- R10: An edge that was blocked produces no bit later, even if the input is still low when the gate reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16_i | input | 1 | One-cycle strobe at 16x the bit rate |
| ir_rx_n_i | input | 1 | Asynchronous active-low pulse input from the infrared receiver |
| tx_busy_i | input | 1 | High while the local transmitter drives light |
| echo_sup_i | input | 1 | 1 blocks receive during and after transmit, 0 passes echoes |
| lat_ticks_i | input | LAT_W | Ticks of blocking kept after transmit ends |
| nrz_rx_o | output | 1 | NRZ receive stream, high when idle |
| rx_led_n_o | output | 1 | Active-low receive activity indicator |

## Verification
The assertions assume that `tick16_i` is a single-cycle strobe that is never held high. They also assume that `tx_busy_i` and `echo_sup_i` are synchronous to `clk`. Only the infrared input is treated as asynchronous. The bench drives every input on the falling clock edge and generates the tick from a free-running divide-by-four counter. It leaves at least one high sample between two input pulses, so each falling edge can be seen. Random pulse starts and widths are chosen so that the results fall well away from the gate's switching cycles. Directed cases cover the exact boundary cycles.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

    // Stretcher: idle line or regenerating one bit-long low.
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_STRETCH = 1'b1
    } str_state_t;

    // Echo gate: receive allowed, blocked by transmit, blocked by latency.
    typedef enum logic [1:0] {
        G_OPEN = 2'd0,
        G_TX   = 2'd1,
        G_HOLD = 2'd2
    } gate_state_t;

endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/irsir_echo_gate.sv
module irsir_echo_gate
    import irsir_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             tx_busy_i,
    input  logic             echo_sup_i,
    input  logic [LAT_W-1:0] lat_ticks_i,
    output logic             blank_o
);
    gate_state_t      st_q, st_n;
    logic [LAT_W-1:0] lat_q, lat_n;

    always_comb begin
        st_n  = st_q;
        lat_n = lat_q;
        unique case (st_q)
            G_OPEN: begin
                if (echo_sup_i && tx_busy_i) st_n = G_TX;
            end
            G_TX: begin
                if (!echo_sup_i) begin
                    st_n = G_OPEN;
                end else if (!tx_busy_i) begin
                    if (lat_ticks_i == '0) begin
                        st_n = G_OPEN;
                    end else begin
                        st_n  = G_HOLD;
                        lat_n = lat_ticks_i;
                    end
                end
            end
            G_HOLD: begin
                if (!echo_sup_i) begin
                    st_n = G_OPEN;
                end else if (tx_busy_i) begin
                    st_n = G_TX;
                end else if (tick_i) begin
                    if (lat_q <= LAT_W'(1)) st_n = G_OPEN;
                    else                    lat_n = lat_q - LAT_W'(1);
                end
            end
            default: st_n = G_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= G_OPEN;
            lat_q <= '0;
        end else begin
            st_q  <= st_n;
            lat_q <= lat_n;
        end
    end

    // Outputs
    always_comb begin
        blank_o = (st_q != G_OPEN);
    end

    // R6
    tx_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(echo_sup_i && tx_busy_i) && echo_sup_i) |-> blank_o);

    // R8
    echo_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(echo_sup_i)) |-> !blank_o);
endmodule

// File: rtl/irsir_stretch.sv
module irsir_stretch
    import irsir_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fall_ok_i,
    input  logic hold_low_i,
    output logic nrz_o,
    output logic led_n_o
);
    localparam int CNT_W = $clog2(BIT_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_TICKS - 1);

    str_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (fall_ok_i) begin
                    st_n  = ST_STRETCH;
                    cnt_n = '0;
                end
            end
            ST_STRETCH: begin
                if (fall_ok_i) begin
                    cnt_n = '0;
                end else if (tick_i) begin
                    if (cnt_q == LAST) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Outputs, registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrz_o   <= 1'b1;
            led_n_o <= 1'b1;
        end else begin
            nrz_o   <= (st_n != ST_STRETCH);
            led_n_o <= !((st_n == ST_STRETCH) || hold_low_i);
        end
    end

    // R2
    edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ok_i |=> !nrz_o);

    // R3
    end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrz_o) |-> $past(tick_i));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STRETCH && fall_ok_i) |=> (cnt_q == '0 && !nrz_o));
endmodule

// File: rtl/irsir_rx_stretch.sv
module irsir_rx_stretch
    import irsir_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BIT_TICKS   = 16,
    parameter int LAT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16_i,
    input  logic             ir_rx_n_i,
    input  logic             tx_busy_i,
    input  logic             echo_sup_i,
    input  logic [LAT_W-1:0] lat_ticks_i,
    output logic             nrz_rx_o,
    output logic             rx_led_n_o
);
    logic ir_lvl, ir_fall, blank, fall_ok, hold_low;

    irsir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ir_rx_n_i),
        .level_o (ir_lvl),
        .fall_o  (ir_fall)
    );

    irsir_echo_gate #(.LAT_W(LAT_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick16_i),
        .tx_busy_i   (tx_busy_i),
        .echo_sup_i  (echo_sup_i),
        .lat_ticks_i (lat_ticks_i),
        .blank_o     (blank)
    );

    assign fall_ok  = ir_fall & ~blank;
    assign hold_low = ~ir_lvl & ~blank;

    irsir_stretch #(.BIT_TICKS(BIT_TICKS)) u_str (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick16_i),
        .fall_ok_i  (fall_ok),
        .hold_low_i (hold_low),
        .nrz_o      (nrz_rx_o),
        .led_n_o    (rx_led_n_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (nrz_rx_o && rx_led_n_o));
endmodule

// File: tb/sim_irsir_rx_stretch.sv
module sim_irsir_rx_stretch;
    localparam int D = 4;
    localparam int N = 300;
    localparam int WMIN = 15 * D + 1;
    localparam int WMAX = 16 * D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       ir_n = 1'b1;
    logic       tx = 1'b0;
    logic       esup = 1'b1;
    logic [7:0] lat = 8'd10;
    logic       nrz, led_n;
    logic [1:0] tdiv;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic nrz_log [0:N];
    logic led_log [0:N];

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign tick = (tdiv == 2'd3);

    irsir_rx_stretch u0 (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick), .ir_rx_n_i(ir_n),
        .tx_busy_i(tx), .echo_sup_i(esup), .lat_ticks_i(lat),
        .nrz_rx_o(nrz), .rx_led_n_o(led_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Input low at edges [s1, s1+w1-1] and [s2, s2+w2-1]; tx high through edge txu.
    task automatic run_wave(input int s1, input int w1, input int s2, input int w2, input int txu);
        for (int i = 0; i < N; i++) begin
            int j;
            j = i + 1;
            ir_n = !((j >= s1 && j < s1 + w1) || (s2 > 0 && j >= s2 && j < s2 + w2));
            tx   = (j <= txu);
            @(posedge clk);
            @(negedge clk);
            nrz_log[j] = nrz;
            led_log[j] = led_n;
        end
        ir_n = 1'b1;
        tx   = 1'b0;
    endtask

    function automatic int first_low();
        for (int i = 1; i <= N; i++) if (nrz_log[i] == 1'b0) return i;
        return -1;
    endfunction

    function automatic int last_low();
        for (int i = N; i >= 1; i--) if (nrz_log[i] == 1'b0) return i;
        return -1;
    endfunction

    function automatic int count_low();
        int c = 0;
        for (int i = 1; i <= N; i++) if (nrz_log[i] == 1'b0) c++;
        return c;
    endfunction

    function automatic bit led_covers();
        for (int i = 1; i <= N; i++) if (nrz_log[i] == 1'b0 && led_log[i] != 1'b0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check_single(input int s, input string tag);
        int f, l, c;
        f = first_low(); l = last_low(); c = count_low();
        chk(f == s + 2, {tag, " start"}, f, s + 2);
        chk(c >= WMIN && c <= WMAX, {tag, " width"}, c, WMAX);
        chk(l - f + 1 == c, {tag, " contiguous"}, l - f + 1, c);
    endtask

    initial begin
        int f, l, c;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(nrz == 1'b1, "R1 nrz in reset", nrz, 1);
        chk(led_n == 1'b1, "R1 led in reset", led_n, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(nrz == 1'b1 && led_n == 1'b1, "R1 idle after reset", {nrz, led_n}, 3);

        // R2 R3: short pulse
        esup = 1'b1; lat = 8'd10;
        run_wave(5, 3, 0, 0, 0);
        check_single(5, "R2/R3");
        chk(nrz_log[6] == 1'b1, "R2 not early", nrz_log[6], 1);

        // R5 R9: pulse longer than a bit
        run_wave(5, 120, 0, 0, 0);
        check_single(5, "R5");
        chk(nrz_log[100] == 1'b1, "R5 no extension", nrz_log[100], 1);
        chk(led_log[100] == 1'b0, "R9 led while input low", led_log[100], 0);
        chk(led_log[N] == 1'b1, "R9 led idle", led_log[N], 1);
        chk(led_covers(), "R9 led covers nrz", 0, 1);

        // R4: directed retrigger
        run_wave(5, 2, 20, 2, 0);
        f = first_low(); l = last_low(); c = count_low();
        chk(f == 7, "R4 start", f, 7);
        chk(l + 1 - 22 >= WMIN && l + 1 - 22 <= WMAX, "R4 extended end", l + 1 - 22, WMAX);
        chk(l - f + 1 == c, "R4 contiguous", l - f + 1, c);

        // R6: edge during transmit with suppression
        run_wave(30, 3, 0, 0, 200);
        chk(count_low() == 0, "R6 echo blocked", count_low(), 0);
        chk(led_log[33] == 1'b1, "R6 led quiet", led_log[33], 1);

        // R8: suppression off
        esup = 1'b0;
        run_wave(30, 3, 0, 0, 200);
        check_single(30, "R8");
        esup = 1'b1;

        // R7: latency window then accepted
        lat = 8'd10;
        run_wave(30, 3, 70, 3, 10);
        check_single(70, "R7");

        // R10: blocked edge held low past reopening
        run_wave(30, 60, 0, 0, 10);
        chk(count_low() == 0, "R10 no late bit", count_low(), 0);

        // R7: zero latency reopens at once
        lat = 8'd0;
        run_wave(13, 3, 0, 0, 10);
        check_single(13, "R7 zero latency");
        lat = 8'd10;

        // R5 R2 R3: random single pulses
        for (int k = 0; k < 20; k++) begin
            int s, w;
            s = $urandom_range(1, 10);
            w = $urandom_range(1, 90);
            run_wave(s, w, 0, 0, 0);
            check_single(s, "R5 random");
        end

        // R4: random retriggers
        for (int k = 0; k < 10; k++) begin
            int s, w, s2;
            s  = $urandom_range(1, 10);
            w  = $urandom_range(1, 10);
            s2 = s + w + 1 + $urandom_range(0, 20);
            run_wave(s, w, s2, $urandom_range(1, 5), 0);
            f = first_low(); l = last_low(); c = count_low();
            chk(f == s + 2, "R4 random start", f, s + 2);
            chk(l + 1 - (s2 + 2) >= WMIN && l + 1 - (s2 + 2) <= WMAX,
                "R4 random end", l + 1 - (s2 + 2), WMAX);
            chk(l - f + 1 == c, "R4 random contiguous", l - f + 1, c);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule